// File: doc/BRIEF.md
# Tracking Error Fault Monitor

This block supervises a tracking angle converter. Each clock it takes the signed difference between the measured angle and the converter's digital angle, already digitized as a two's-complement word, and decides whether the loop has lost track. A fault is reported on an active-low flag when the error magnitude stays at or above a threshold for a whole filter window, or at once when the front end reports that the input signal is lost.

The threshold scales with the resolution the converter runs at. The filter window is a number of clock cycles derived from the clock frequency and a window length in microseconds, so brief error bursts after a step input do not raise the flag. Longer transients, such as those at power-up, may still raise it. The flag clears on the first clean cycle.

Top module: `trk_err_bit_mon`

## Requirements
- R1: After a synchronous active-low reset, `fault_n` is 1 and the persistence window is empty.
- R2: `fault_n` is active low: 0 means fault, 1 means healthy.
- R3: If the error is large at N consecutive rising edges, `fault_n` is 0 after the N-th edge and stays 1 after only N-1 such edges. N = CLK_HZ*FILT_US/1e6, and is at least 1.
- R4: `los_in` high at an edge drives `fault_n` to 0 after that edge, whatever the error value.
- R5: At the first edge with a small error and `los_in` low, `fault_n` returns to 1 after that edge.
- R6: The error counts as large when |err_in| >= THR_LSB << 2*(3-res_sel). Here `res_sel` 0, 1, 2 and 3 select 10, 12, 14 and 16 bits. The error is expressed in LSBs of the finest (16-bit) weight.
- R7: Magnitude is symmetric in sign. The most negative code saturates to the largest positive value and is judged by that value.
- R8: A single small-error edge restarts the window, so a later run must again reach N edges.
- R9: A large error held beyond N edges keeps `fault_n` at 0. The window counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_in | input | ERR_W | Signed tracking error in finest-weight LSBs |
| los_in | input | 1 | Loss-of-signal indication, active high |
| res_sel | input | 2 | Resolution code (0:10, 1:12, 2:14, 3:16 bits) |
| fault_n | output | 1 | Fault flag, active low |

## Verification
The cases that are hardest to reach from the ports are the edges of the window and of the threshold. These are a run that stops exactly one edge short, a run that a single quiet sample breaks, and magnitudes one LSB either side of the threshold at every resolution and in both signs. The bench shortens the window to eight cycles by parameter. It then sweeps every resolution code and both signs at offsets of -2 to +2 around the threshold, holding each value for N-1 edges and then one more. It also drives the most negative code and a long hold that pushes the counter into saturation.

// File: rtl/trk_err_bit_pkg.sv
// Package: shared resolution encoding for the tracking error monitor.
// Assumes the four resolution codes step by two bits each.
package trk_err_bit_pkg;
    localparam int RES_CODES = 4;
    localparam int RES_W     = 2;

    typedef enum logic [RES_W-1:0] {
        RES_10 = 2'd0,
        RES_12 = 2'd1,
        RES_14 = 2'd2,
        RES_16 = 2'd3
    } res_code_e;
endpackage

// File: rtl/err_mag_abs.sv
// Module: absolute value of a two's-complement error word.
// Assumes ERR_W >= 2. The most negative code saturates to the all-ones magnitude.
module err_mag_abs #(
    parameter int ERR_W = 16
) (
    input  logic signed [ERR_W-1:0] err_in,
    output logic        [ERR_W-2:0] mag_out
);
    localparam logic [ERR_W-1:0] MOST_NEG = {1'b1, {(ERR_W-1){1'b0}}};

    logic [ERR_W-1:0] neg_val;

    // Negate the raw word for the negative branch.
    always_comb neg_val = -err_in;

    // Pick the sign branch, saturating the single unrepresentable case.
    always_comb begin
        if (!err_in[ERR_W-1]) begin
            mag_out = err_in[ERR_W-2:0];
        end else if (err_in == MOST_NEG) begin
            mag_out = {(ERR_W-1){1'b1}};
        end else begin
            mag_out = neg_val[ERR_W-2:0];
        end
    end
endmodule

// File: rtl/err_thresh_cmp.sv
// Module: compares an error magnitude against a threshold scaled by resolution.
// Assumes a coarser resolution means each of its LSBs spans 4x the finer one.
// A threshold that does not fit the magnitude width saturates, so it never trips.
module err_thresh_cmp
    import trk_err_bit_pkg::*;
#(
    parameter int ERR_W   = 16,
    parameter int THR_LSB = 100
) (
    input  logic [ERR_W-2:0] mag_in,
    input  logic [RES_W-1:0] res_sel,
    output logic             big_out
);
    localparam int MAG_W = ERR_W - 1;

    logic [MAG_W:0] thr_tab [RES_CODES];

    // One threshold per resolution code, shifted by two bits per step.
    for (genvar g = 0; g < RES_CODES; g++) begin : g_thr
        localparam longint SCALED = longint'(THR_LSB) << (2 * (RES_CODES - 1 - g));
        localparam longint LIMIT  = longint'(1) << MAG_W;
        localparam longint CAPPED = (SCALED > LIMIT) ? LIMIT : SCALED;
        assign thr_tab[g] = CAPPED[MAG_W:0];
    end

    // Large when the magnitude reaches the selected threshold.
    always_comb big_out = ({1'b0, mag_in} >= thr_tab[res_sel]);
endmodule

// File: rtl/persist_window.sv
// Module: counts consecutive large-error edges and saturates at the window length.
// Assumes WIN >= 1. hit_out marks the edge that completes the window.
module persist_window #(
    parameter int WIN   = 8,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             big_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(WIN);

    // The window is complete when this edge brings the run to WIN.
    always_comb hit_out = big_in && (cnt_q >= LAST);

    // Run counter: cleared by a small sample, held at TOP once reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!big_in) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/trk_err_bit_mon.sv
// Module: tracking error built-in-test monitor (top).
// Raises fault_n low after a persistent large error or at once on loss of signal.
// Assumes err_in and los_in are synchronous to clk.
module trk_err_bit_mon
    import trk_err_bit_pkg::*;
#(
    parameter int ERR_W   = 16,
    parameter int THR_LSB = 100,
    parameter int CLK_HZ  = 100_000_000,
    parameter int FILT_US = 500
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic                    los_in,
    input  logic [RES_W-1:0]        res_sel,
    output logic                    fault_n
);
    localparam longint FILT_PROD = longint'(CLK_HZ) * longint'(FILT_US);
    localparam longint FILT_RAW  = FILT_PROD / 64'd1_000_000;
    localparam int     FILT_CYC  = (FILT_RAW < 1) ? 1 : int'(FILT_RAW);
    localparam int     CNT_W     = $clog2(FILT_CYC + 1);

    logic [ERR_W-2:0] mag_w;
    logic             big_w;
    logic [CNT_W-1:0] cnt_w;
    logic             hit_w;

    err_mag_abs #(.ERR_W(ERR_W)) u_abs (
        .err_in  (err_in),
        .mag_out (mag_w)
    );

    err_thresh_cmp #(.ERR_W(ERR_W), .THR_LSB(THR_LSB)) u_cmp (
        .mag_in  (mag_w),
        .res_sel (res_sel),
        .big_out (big_w)
    );

    persist_window #(.WIN(FILT_CYC), .CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .big_in  (big_w),
        .cnt_q   (cnt_w),
        .hit_out (hit_w)
    );

    // Flag register: loss of signal or a completed window drive it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_n <= 1'b1;
        end else begin
            fault_n <= !(los_in || hit_w);
        end
    end
endmodule

// File: rtl/trk_err_bit_mon_chk.sv
// Module: property checker for the tracking error monitor, attached by bind.
module trk_err_bit_mon_chk #(
    parameter int CNT_W    = 4,
    parameter int FILT_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             los_in,
    input logic             big,
    input logic [CNT_W-1:0] cnt_q,
    input logic             fault_n
);
    p_los_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
        los_in |=> !fault_n);

    p_clean_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_in && !big) |=> fault_n);

    p_small_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !big |=> (cnt_q == '0));

    p_no_early_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> ($past(los_in) ||
                            ($past(big) && ($past(cnt_q) >= CNT_W'(FILT_CYC - 1)))));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FILT_CYC));
endmodule

bind trk_err_bit_mon trk_err_bit_mon_chk #(.CNT_W(CNT_W), .FILT_CYC(FILT_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .los_in  (los_in),
    .big     (big_w),
    .cnt_q   (cnt_w),
    .fault_n (fault_n)
);

// File: tb/trk_err_bit_mon_tb.sv
module trk_err_bit_mon_tb;
    localparam int N    = 8;   // 1 MHz nominal * 8 us window
    localparam int BASE = 100;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] err_in = '0;
    logic               los_in = 1'b0;
    logic [1:0]         res_sel = 2'd3;
    logic               fault_n;
    int                 n_chk = 0;
    int                 n_bad = 0;
    int                 cyc = 0;

    trk_err_bit_mon #(.ERR_W(16), .THR_LSB(BASE), .CLK_HZ(1_000_000), .FILT_US(8)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_in  (err_in),
        .los_in  (los_in),
        .res_sel (res_sel),
        .fault_n (fault_n)
    );

    always #5 clk = ~clk;

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic bit exp_big(int v, int r);
        int m = (v < 0) ? -v : v;
        if (v == -32768) m = 32767;
        return m >= (BASE << (2 * (3 - r)));
    endfunction

    // Apply inputs at a falling edge and return at the next falling edge.
    task automatic tick(int v, bit l);
        err_in = 16'(v);
        los_in = l;
        @(negedge clk);
    endtask

    task automatic check(bit exp, string req);
        n_chk = n_chk + 1;
        if (fault_n !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: fault_n actual %b expected %b (err=%0d res=%0d)",
                     req, fault_n, exp, err_in, res_sel);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, "R1 reset state");
        rst_n = 1'b1;
        tick(0, 0);
        check(1'b1, "R1 healthy after reset");

        // Threshold sweep around every resolution, both signs.
        for (int r = 0; r < 4; r++) begin
            res_sel = 2'(r);
            for (int s = 0; s < 2; s++) begin
                for (int d = -2; d <= 2; d++) begin
                    int thr = BASE << (2 * (3 - r));
                    int v = (s == 0) ? (thr + d) : -(thr + d);
                    bit b = exp_big(v, r);
                    tick(0, 0);
                    check(1'b1, "R5 clean start");
                    for (int k = 0; k < N - 1; k++) tick(v, 0);
                    check(1'b1, "R3 no fault at N-1");
                    tick(v, 0);
                    check(!b, "R6 threshold after N edges");
                    tick(0, 0);
                    check(1'b1, "R5 clears on first clean edge");
                end
            end
        end

        // Most negative code and largest positive at the coarsest threshold.
        res_sel = 2'd0;
        for (int k = 0; k < N; k++) tick(-32768, 0);
        check(!exp_big(-32768, 0), "R7 most negative saturates");
        tick(0, 0);
        for (int k = 0; k < N; k++) tick(32767, 0);
        check(!exp_big(32767, 0), "R7 largest positive");
        tick(0, 0);
        check(1'b1, "R2 healthy is high");

        // A single quiet sample restarts the window.
        res_sel = 2'd3;
        for (int k = 0; k < N - 1; k++) tick(-150, 0);
        tick(99, 0);
        for (int k = 0; k < N - 1; k++) tick(150, 0);
        check(1'b1, "R8 window restarted");
        tick(150, 0);
        check(1'b0, "R8 fault after full run");

        // Long hold keeps the fault; counter must not wrap.
        for (int k = 0; k < 4 * N; k++) begin
            tick(-200, 0);
            check(1'b0, "R9 held fault");
        end
        tick(0, 0);
        check(1'b1, "R5 release after hold");

        // Loss of signal forces a fault with any error value.
        tick(0, 1);
        check(1'b0, "R4 los with zero error");
        tick(50, 1);
        check(1'b0, "R4 los with small error");
        tick(50, 0);
        check(1'b1, "R5 los released");
        for (int k = 0; k < 3; k++) tick(500, 0);
        tick(500, 1);
        check(1'b0, "R4 los mid window");
        tick(0, 0);
        check(1'b1, "R2 flag returns high");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule